// File: doc/BRIEF.md
# Serial Flash Buffer and Status Read Front End

This block is the slave-side command decoder of a serial flash device, for the commands that read data back to the host. While chip select is low, the host shifts an opcode and its framing bits in on SI. Two kinds of command are served. A buffer read returns bytes from one of two 264-byte on-chip data buffers, starting at a host-given byte address and wrapping inside the chosen buffer. A status read returns the device status byte, repeated for as long as the host keeps clocking.

The serial pins are sampled by the block's own system clock through a short synchronizer, and SCK edges are detected in that clock domain. SCK must therefore run well below the system clock. SI is taken on SCK rising edges and SO moves on SCK falling edges, so SPI mode 0 and SPI mode 3 behave the same. The buffers sit outside the block behind two asynchronous read ports: the block presents an address and takes the byte in the same cycle. The status bits come from a live input. SO is given as a data bit plus an output enable for the pad driver. A deasserted enable is the high-impedance state.

Top module: `spi_flash_reader`

## Requirements
- R1: During reset and while cs_n is high, so_oe is 0 (SO is high impedance).
- R2: The opcode is taken MSB first from the first 8 SI bits. Bit 7 of the opcode is ignored. Values 0x54 and 0xD4 read buffer 1 (buf1_data), and values 0x56 and 0xD6 read buffer 2 (buf2_data).
- R3: A buffer read frame is 8 opcode bits, then 15 don't-care bits, then a 9-bit start address sent MSB first, then 8 don't-care bits. so_oe stays 0 through all 40 bits. The first data bit is driven on the SCK falling edge that follows the 40th rising edge.
- R4: Each data byte goes out MSB first over 8 SCK cycles. Successive bytes come from successive byte addresses.
- R5: After byte 263 the read continues at byte 0 of the same buffer. A start address above 263 returns that one byte and then continues at byte 0.
- R6: Opcode 0x57 or 0xD7 starts a status read. Its first bit is driven on the falling edge right after the 8th opcode bit. The byte sent is {status_in[4:0], 3'b000}, MSB first.
- R7: The status byte repeats without limit while cs_n is low. Each repetition captures status_in at its first falling edge and holds that value for all 8 bits.
- R8: A rising cs_n ends any read and returns so_oe to 0. The next command after cs_n falls again is decoded from its first bit.
- R9: Any other opcode leaves so_oe at 0 until cs_n goes high.
- R10: Reads give identical data whether SCK idles low (mode 0) or high (mode 3).
- R11: SI is sampled on SCK rising edges. SO changes only after SCK falling edges, so it is stable across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid when so_oe is 1 |
| so_oe | output | 1 | Pad enable for SO; 0 means high impedance |
| buf1_addr | output | 9 | Byte address into buffer 1 |
| buf1_rd | output | 1 | One-cycle pulse when a buffer 1 byte is taken |
| buf1_data | input | 8 | Byte at buf1_addr (asynchronous read) |
| buf2_addr | output | 9 | Byte address into buffer 2 |
| buf2_rd | output | 1 | One-cycle pulse when a buffer 2 byte is taken |
| buf2_data | input | 8 | Byte at buf2_addr (asynchronous read) |
| status_in | input | 5 | Live device status, upper five bits of the status byte |

## Verification
The assertions assume that each SCK level lasts several system clocks longer than the synchronizer delay, so every serial edge is seen exactly once. They also assume that cs_n moves only while SCK is at a level and not in the same cycle as an SCK edge. The bench holds each SCK half period at ten system clocks and changes cs_n a full half period away from any SCK edge. It alters status_in only between falling edges. The buffer ports are modelled as combinational functions of the address, which matches the asynchronous read the block expects.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  // opcode values with the top bit dropped; that bit does not affect the command
  localparam logic [6:0] OPC_BUF1 = 7'h54;
  localparam logic [6:0] OPC_BUF2 = 7'h56;
  localparam logic [6:0] OPC_STAT = 7'h57;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_FRAME,
    ST_BUF_DATA,
    ST_STAT_DATA,
    ST_IGNORE
  } rd_state_e;

  typedef enum logic [1:0] {
    CMD_BUF1,
    CMD_BUF2,
    CMD_STAT,
    CMD_NONE
  } rd_cmd_e;

  function automatic rd_cmd_e decode_opcode(input logic [7:0] op);
    rd_cmd_e c;
    case (op[6:0])
      OPC_BUF1: c = CMD_BUF1;
      OPC_BUF2: c = CMD_BUF2;
      OPC_STAT: c = CMD_STAT;
      default:  c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);
  // pin order inside each stage: {si, cs_n, sck}
  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b010;

  logic [STAGES-1:0][PIN_W-1:0] stage_q, stage_d;
  logic                         sck_prev_q, sck_prev_d;
  logic [PIN_W-1:0]             pins_s;

  always_comb begin
    stage_d[0] = {si, cs_n, sck};
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  assign pins_s     = stage_q[STAGES-1];
  assign sck_prev_d = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= {STAGES{PIN_RST}};
      sck_prev_q <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      sck_prev_q <= sck_prev_d;
    end
  end

  assign sck_rise = pins_s[0] & ~sck_prev_q;
  assign sck_fall = ~pins_s[0] & sck_prev_q;
  assign cs_act   = ~pins_s[1];
  assign si_s     = pins_s[2];

endmodule

// File: rtl/rd_cmd_ctrl.sv
module rd_cmd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int BUF_BYTES  = 264,
  parameter int ADDR_W     = 9,
  parameter int OP_BITS    = 8,
  parameter int LEAD_DUMMY = 15,
  parameter int TAIL_DUMMY = 8,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  output logic              load,
  output logic              shift,
  output logic              stat_sel,
  output logic              buf_sel,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int FRAME_BITS = OP_BITS + LEAD_DUMMY + ADDR_W + TAIL_DUMMY;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int ADDR_LO    = OP_BITS + LEAD_DUMMY;
  localparam int ADDR_HI    = ADDR_LO + ADDR_W - 1;
  localparam int LAST_ADDR  = BUF_BYTES - 1;
  localparam int PH_W       = $clog2(BYTE_W);

  rd_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [OP_BITS-1:0]  op_q, op_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [PH_W-1:0]     phase_q, phase_d;
  logic                sel_q, sel_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    phase_d = phase_q;
    sel_d   = sel_q;
    load    = 1'b0;
    shift   = 1'b0;
    if (!cs_act) begin
      state_d = ST_OPCODE;
      cnt_d   = '0;
      phase_d = '0;
    end else begin
      case (state_q)
        ST_OPCODE: begin
          if (sck_rise) begin
            op_d  = {op_q[OP_BITS-2:0], si_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(OP_BITS - 1)) begin
              case (decode_opcode(op_d))
                CMD_BUF1: begin state_d = ST_FRAME; sel_d = 1'b0; end
                CMD_BUF2: begin state_d = ST_FRAME; sel_d = 1'b1; end
                CMD_STAT: state_d = ST_STAT_DATA;
                default:  state_d = ST_IGNORE;
              endcase
            end
          end
        end
        ST_FRAME: begin
          if (sck_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q >= CNT_W'(ADDR_LO) && cnt_q <= CNT_W'(ADDR_HI)) begin
              addr_d = {addr_q[ADDR_W-2:0], si_s};
            end
            if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
              state_d = ST_BUF_DATA;
            end
          end
        end
        ST_BUF_DATA, ST_STAT_DATA: begin
          if (sck_fall) begin
            phase_d = phase_q + 1'b1;
            if (phase_q == '0) begin
              load = 1'b1;
              if (state_q == ST_BUF_DATA) begin
                addr_d = (addr_q >= ADDR_W'(LAST_ADDR)) ? '0 : addr_q + 1'b1;
              end
            end else begin
              shift = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      phase_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      phase_q <= phase_d;
      sel_q   <= sel_d;
    end
  end

  assign stat_sel = (state_q == ST_STAT_DATA);
  assign buf_sel  = sel_q;
  assign rd_addr  = addr_q;

  // R3: data phase is entered only once the full frame has been counted
  assert_frame_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUF_DATA && $past(state_q) != ST_BUF_DATA) |-> (cnt_q == CNT_W'(FRAME_BITS)));

  // R5: after any buffer byte is taken the next address lies inside the buffer
  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && state_q == ST_BUF_DATA) |=> (addr_q <= ADDR_W'(LAST_ADDR)));

  // R9: an unrecognised command stays parked while selected
  assert_ignore_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE && cs_act) |=> (state_q == ST_IGNORE));

endmodule

// File: rtl/so_shifter.sv
module so_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              so_bit,
  output logic              so_en
);
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              en_q, en_d;

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = din;
    end else if (shift) begin
      sr_d = {sr_q[BYTE_W-2:0], 1'b0};
    end
    en_d = en_q;
    if (!cs_act) begin
      en_d = 1'b0;
    end else if (load) begin
      en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      en_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      en_q <= en_d;
    end
  end

  assign so_bit = sr_q[BYTE_W-1];
  assign so_en  = en_q;

  // R4: the first bit driven after a load is the top bit of the loaded byte
  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (so_bit == $past(din[BYTE_W-1])));

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import flash_rd_pkg::*;
#(
  parameter int BUF_BYTES   = 264,
  parameter int ADDR_W      = 9,
  parameter int STAT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] buf1_addr,
  output logic              buf1_rd,
  input  logic [7:0]        buf1_data,
  output logic [ADDR_W-1:0] buf2_addr,
  output logic              buf2_rd,
  input  logic [7:0]        buf2_data,
  input  logic [STAT_W-1:0] status_in
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - STAT_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              sck_rise, sck_fall, cs_act, si_s;
  logic              load, shift, stat_sel, buf_sel;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] load_byte;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .sck      (sck),
    .cs_n     (cs_n),
    .si       (si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .si_s     (si_s)
  );

  rd_cmd_ctrl #(
    .BUF_BYTES (BUF_BYTES),
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s),
    .load     (load),
    .shift    (shift),
    .stat_sel (stat_sel),
    .buf_sel  (buf_sel),
    .rd_addr  (rd_addr)
  );

  // byte source: live status padded with zeros, or the selected buffer
  always_comb begin
    if (stat_sel) begin
      load_byte = {status_in, {PAD_W{1'b0}}};
    end else if (buf_sel) begin
      load_byte = buf2_data;
    end else begin
      load_byte = buf1_data;
    end
  end

  so_shifter #(.BYTE_W(BYTE_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .cs_act (cs_act),
    .load   (load),
    .shift  (shift),
    .din    (load_byte),
    .so_bit (so),
    .so_en  (so_oe)
  );

  assign buf1_addr = rd_addr;
  assign buf2_addr = rd_addr;
  assign buf1_rd   = load & ~stat_sel & ~buf_sel;
  assign buf2_rd   = load & ~stat_sel & buf_sel;

  // R8: deselect always releases the pad
  assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cs_act |=> !so_oe);

  // R2: never both buffers at once
  assert_single_buffer_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0({buf1_rd, buf2_rd}));

  // R11: driven SO only moves right after a falling SCK edge
  assert_so_moves_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(sck_fall));

  // R6: a status byte starts with the top live status bit
  assert_status_msb_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (load && stat_sel) |=> (so == $past(status_in[STAT_W-1])));

endmodule

// File: tb/test_spi_flash_reader.sv
`timescale 1ns/1ps
module test_spi_flash_reader;
  localparam int H = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic [4:0] status_in = 5'b0;
  logic       so, so_oe, buf1_rd, buf2_rd;
  logic [8:0] buf1_addr, buf2_addr;
  logic [7:0] buf1_data, buf2_data;
  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] b1_val(input logic [8:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd5 + 16'd3;
    return t[7:0] ^ {a[8], 7'b0};
  endfunction

  function automatic logic [7:0] b2_val(input logic [8:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd11;
    return t[7:0] ^ 8'hC3 ^ {1'b0, a[8], 6'b0};
  endfunction

  function automatic logic [8:0] nxt(input logic [8:0] a);
    return (a >= 9'd263) ? 9'd0 : a + 9'd1;
  endfunction

  assign buf1_data = b1_val(buf1_addr);
  assign buf2_data = b2_val(buf2_addr);

  spi_flash_reader i_spi_flash_reader (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe),
    .buf1_addr(buf1_addr), .buf1_rd(buf1_rd), .buf1_data(buf1_data),
    .buf2_addr(buf2_addr), .buf2_rd(buf2_rd), .buf2_data(buf2_data),
    .status_in(status_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_begin(input logic m3);
    sck = m3;
    #(H);
    cs_n = 1'b0;
    #(H);
  endtask

  task automatic spi_end(input logic m3);
    if (!m3) begin
      sck = 1'b0;
      #(H);
    end
    cs_n = 1'b1;
    #(4*H);
  endtask

  // one SCK cycle: fall, sample before rise, rise, sample at end of high half
  task automatic spi_bit(input logic b, output logic d_lo, output logic oe, output logic d_hi);
    sck = 1'b0;
    si  = b;
    #(H);
    d_lo = so;
    oe   = so_oe;
    sck  = 1'b1;
    #(H);
    d_hi = so;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, inout logic quiet);
    logic d, oe, dh;
    for (int i = n - 1; i >= 0; i--) begin
      spi_bit(v[i], d, oe, dh);
      if (oe) quiet = 1'b0;
    end
  endtask

  task automatic read_bits(input int n, inout logic [7:0] v, inout logic steady);
    logic d, oe, dh;
    for (int i = 0; i < n; i++) begin
      spi_bit(1'b0, d, oe, dh);
      v = {v[6:0], d};
      if (!oe || d != dh) steady = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 so_oe in reset", so_oe, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 so_oe after reset", so_oe, 0);
  endtask

  task automatic t_buf(input logic [7:0] op, input logic [8:0] start, input int n,
                       input logic m3, input string req);
    logic       quiet = 1'b1;
    logic [7:0] v = '0;
    logic       steady = 1'b1;
    logic [8:0] a = start;
    logic       sel2 = (op[6:0] == 7'h56);
    spi_begin(m3);
    send_bits(32'(op), 8, quiet);
    send_bits(32'h0, 15, quiet);
    send_bits(32'(start), 9, quiet);
    send_bits(32'h0, 8, quiet);
    chk({req, " R3 quiet during frame"}, quiet, 1);
    for (int k = 0; k < n; k++) begin
      read_bits(8, v, steady);
      chk({req, " R4 data byte"}, v, sel2 ? b2_val(a) : b1_val(a));
      a = nxt(a);
    end
    chk({req, " R11 SO steady across rise"}, steady, 1);
    spi_end(m3);
    chk({req, " R8 released after cs_n"}, so_oe, 0);
  endtask

  task automatic t_status(input logic [7:0] op, input logic m3);
    logic       quiet = 1'b1;
    logic [7:0] v = '0;
    logic       steady = 1'b1;
    status_in = 5'b10110;
    spi_begin(m3);
    send_bits(32'(op), 8, quiet);
    read_bits(8, v, steady);
    chk("R6 first status byte", v, 8'hB0);
    status_in = 5'b01101;
    read_bits(3, v, steady);
    status_in = 5'b11111;
    read_bits(5, v, steady);
    chk("R7 byte holds value captured at its start", v, 8'h68);
    read_bits(8, v, steady);
    chk("R7 repetition picks up new status", v, 8'hF8);
    chk("R6 R11 status steady", steady, 1);
    spi_end(m3);
    chk("R8 released after status", so_oe, 0);
  endtask

  task automatic t_unknown();
    logic quiet = 1'b1;
    spi_begin(1'b0);
    send_bits(32'h12, 8, quiet);
    send_bits(32'hA5F0, 16, quiet);
    chk("R9 unknown opcode keeps SO off", quiet, 1);
    spi_end(1'b0);
  endtask

  task automatic t_abort();
    logic       quiet = 1'b1;
    logic [7:0] v = '0;
    logic       steady = 1'b1;
    spi_begin(1'b1);
    send_bits(32'h54, 8, quiet);
    send_bits(32'h0, 15, quiet);
    send_bits(32'd10, 9, quiet);
    send_bits(32'h0, 8, quiet);
    read_bits(8, v, steady);
    chk("R8 byte before abort", v, b1_val(9'd10));
    read_bits(3, v, steady);
    spi_end(1'b1);
    chk("R8 abort releases SO", so_oe, 0);
    status_in = 5'b00011;
    spi_begin(1'b0);
    send_bits(32'hD7, 8, quiet);
    read_bits(8, v, steady);
    chk("R8 fresh command after abort", v, 8'h18);
    spi_end(1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_buf(8'h54, 9'd5, 3, 1'b0, "R2 R10 buf1 mode0");
    t_buf(8'hD6, 9'd100, 3, 1'b1, "R2 R10 buf2 mode3");
    t_buf(8'hD4, 9'd100, 2, 1'b1, "R2 R10 buf1 opcode D4");
    t_buf(8'h56, 9'd5, 2, 1'b0, "R2 buf2 opcode 56");
    t_buf(8'h54, 9'd262, 4, 1'b0, "R5 wrap 263 to 0");
    t_buf(8'hD6, 9'd300, 3, 1'b1, "R5 start above 263");
    t_status(8'h57, 1'b0);
    t_status(8'hD7, 1'b1);
    t_unknown();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule